// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block sits between a synchronous user port and an external asynchronous static RAM of 256K words by 16 bits. The RAM has active-low chip select, write enable, output enable and two active-low byte enables. The user issues single word-wide read or write requests through a request/ready handshake, with an 18-bit word address, 16 bits of write data and a 2-bit lane enable. The controller turns each request into strobe sequences whose lengths are whole numbers of clock cycles. These counts are computed at elaboration from the memory's nanosecond limits and the clock period.

A small state machine runs each access. `ST_IDLE` holds ready high. An accepted read moves to `ST_RD_ACC`. An accepted write moves to `ST_WR_STROBE`, or first to `ST_WR_TURN` when the previous access was a read. `ST_RD_ACC` returns to `ST_IDLE` when its counter expires. `ST_WR_TURN` moves to `ST_WR_STROBE` when its counter expires. `ST_WR_STROBE` moves to `ST_WR_HOLD` when its counter expires. `ST_WR_HOLD` always returns to `ST_IDLE` after one cycle.

The memory data bus is split into an output word, an input word and a drive enable. A pad ring or test model joins these into the bidirectional bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, `mem_cs_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_lane_n` are high, `mem_dq_oe` is low, `rd_valid` is low and `ready` is high.
- R2: A read is accepted on a rising edge where `req` and `ready` are both high and `wr` is low. For the next RD_CYC cycles (6 by default, the ceiling of the larger of read cycle time and address access time over the clock period), `mem_cs_n` and `mem_oe_n` are low and `mem_we_n` is high. Over the same cycles `mem_lane_n` equals the inverted `lane_en`, where bit 0 is the lower lane (data bits 7:0) and bit 1 is the upper lane (bits 15:8).
- R3: Read data is sampled at the clock edge that ends the last read cycle. In the following cycle `rd_valid` is high for exactly one cycle, `mem_oe_n` is already high, and `rd_data` holds the sampled lanes. Any lane whose `lane_en` bit was 0 reads as zero.
- R4: An accepted write holds `mem_cs_n` and `mem_we_n` low for WP_CYC cycles (5 by default, the ceiling of the largest of write pulse width, select-to-end-of-write, data setup, and write cycle time minus one clock). During those cycles `mem_oe_n` is high, `mem_dq_oe` is high and `mem_dq_out` equals `wr_data`.
- R5: When the write strobe ends, `mem_cs_n` and `mem_we_n` rise together. In the cycle that follows, `mem_dq_oe` stays high and the address, lane enables and `mem_dq_out` are unchanged. After that cycle the drivers turn off.
- R6: When a write is accepted and the previous access was a read, TA_CYC cycles (2 by default, the ceiling of the output release time) pass first. During them all strobes are high and `mem_dq_oe` is low. Only then does the write strobe start.
- R7: `ready` is low while an access, turnaround or hold cycle is in progress. A request held high while `ready` is low is accepted at the first edge where `ready` is high, and it is not lost.
- R8: A write changes only the memory lanes whose `lane_en` bit is 1. A write with `lane_en` = 0 changes nothing, which a later read of the same address shows.
- R9: `mem_addr` equals the accepted address and stays stable for every cycle in which `mem_cs_n` is low.
- R10: `mem_dq_oe` is never high in a cycle where `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until accepted |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wr_data | input | 16 | Write data word |
| lane_en | input | 2 | Lane enable, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | High when a request can be accepted |
| rd_data | output | 16 | Returned read data |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| mem_addr | output | 18 | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lane_n | output | 2 | Memory byte enables, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data returned from the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |

## Verification
A wrong state or counter value shows up at the strobes in the cycle it occurs. Every cycle is compared against a queue of expected strobe patterns, so a window that is one cycle short or long, or a missing turnaround, fails at that cycle. A lost lane setting, or a capture taken too early, appears at the next read of the address. The memory model returns filler bytes until a full access time has elapsed, and a rd_data mismatch then names the lane. A request lost while ready is low leaves the expectation queue and the strobes out of step, and the watchdog reports a hang.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_TURN,
        ST_WR_STROBE,
        ST_WR_HOLD
    } ctrl_state_t;

    // Whole clock cycles covering a nanosecond limit, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_CYC = 6,
    parameter int unsigned WP_CYC = 5,
    parameter int unsigned TA_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_wr,
    output logic ready,
    output logic accept,
    output logic capture,
    output logic cs_n,
    output logic we_n,
    output logic oe_n,
    output logic drive,
    output logic rvalid
);

    localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, WP_CYC), TA_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TA_CYC - 1);

    ctrl_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_rd_q, last_rd_d;
    logic             cnt_done;

    assign cnt_done = (cnt_q == '0);

    // Next-state and counter decision
    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_done ? '0 : cnt_q - 1'b1;
        last_rd_d = last_rd_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    if (req_wr) begin
                        last_rd_d = 1'b0;
                        if (last_rd_q) begin
                            st_d  = ST_WR_TURN;
                            cnt_d = TA_LAST;
                        end else begin
                            st_d  = ST_WR_STROBE;
                            cnt_d = WP_LAST;
                        end
                    end else begin
                        last_rd_d = 1'b1;
                        st_d      = ST_RD_ACC;
                        cnt_d     = RD_LAST;
                    end
                end
            end
            ST_RD_ACC: begin
                if (cnt_done) st_d = ST_IDLE;
            end
            ST_WR_TURN: begin
                if (cnt_done) begin
                    st_d  = ST_WR_STROBE;
                    cnt_d = WP_LAST;
                end
            end
            ST_WR_STROBE: begin
                if (cnt_done) st_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                st_d = ST_IDLE;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    assign ready   = (st_q == ST_IDLE);
    assign accept  = ready && req;
    assign capture = (st_q == ST_RD_ACC) && cnt_done;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            last_rd_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            last_rd_q <= last_rd_d;
        end
    end

    // Registered strobes decoded from the next state, so they never glitch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n   <= 1'b1;
            we_n   <= 1'b1;
            oe_n   <= 1'b1;
            drive  <= 1'b0;
            rvalid <= 1'b0;
        end else begin
            cs_n   <= !((st_d == ST_RD_ACC) || (st_d == ST_WR_STROBE));
            we_n   <= !(st_d == ST_WR_STROBE);
            oe_n   <= !(st_d == ST_RD_ACC);
            drive  <= (st_d == ST_WR_STROBE) || (st_d == ST_WR_HOLD);
            rvalid <= capture;
        end
    end

    assert_idle_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cs_n && we_n && oe_n))
        else $error("strobe active while ready");

    assert_read_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!cs_n && we_n))
        else $error("output enable without proper select");

    assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cs_n && drive && oe_n))
        else $error("write strobe without select or drive");

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> oe_n)
        else $error("drivers on while memory outputs enabled");

    assert_hold_after_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (drive && cs_n))
        else $error("drivers released at end of write");

    assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid)
        else $error("read valid longer than one cycle");

    assert_rvalid_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> oe_n)
        else $error("output enable still low with read valid");

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              en_in,
    input  logic [LANE_W-1:0] wdata_in,
    input  logic              capture,
    input  logic [LANE_W-1:0] dq_in,
    output logic              lane_n,
    output logic [LANE_W-1:0] dq_out,
    output logic [LANE_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_n <= 1'b1;
            dq_out <= '0;
        end else if (load) begin
            lane_n <= !en_in;
            dq_out <= wdata_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= lane_n ? '0 : dq_in;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned T_RC_NS   = 55,
    parameter int unsigned T_AA_NS   = 55,
    parameter int unsigned T_WC_NS   = 55,
    parameter int unsigned T_WP_NS   = 45,
    parameter int unsigned T_CW_NS   = 45,
    parameter int unsigned T_DW_NS   = 25,
    parameter int unsigned T_REL_NS  = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [DATA_W/8-1:0]  lane_en,
    output logic                 ready,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_cs_n,
    output logic                 mem_we_n,
    output logic                 mem_oe_n,
    output logic [DATA_W/8-1:0]  mem_lane_n,
    output logic [DATA_W-1:0]    mem_dq_out,
    input  logic [DATA_W-1:0]    mem_dq_in,
    output logic                 mem_dq_oe
);

    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned RD_CYC = ns_to_cycles(max_u(T_RC_NS, T_AA_NS), CLK_NS);
    localparam int unsigned WR_MIN = (T_WC_NS > CLK_NS) ? (T_WC_NS - CLK_NS) : 0;
    localparam int unsigned WP_CYC = ns_to_cycles(
        max_u(max_u(T_WP_NS, T_CW_NS), max_u(T_DW_NS, WR_MIN)), CLK_NS);
    localparam int unsigned TA_CYC = ns_to_cycles(T_REL_NS, CLK_NS);

    logic accept;
    logic capture;

    sram_ctrl_fsm #(
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .TA_CYC (TA_CYC)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .req_wr  (wr),
        .ready   (ready),
        .accept  (accept),
        .capture (capture),
        .cs_n    (mem_cs_n),
        .we_n    (mem_we_n),
        .oe_n    (mem_oe_n),
        .drive   (mem_dq_oe),
        .rvalid  (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
        end else if (accept) begin
            mem_addr <= addr;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_byte_lane #(.LANE_W(8)) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .en_in    (lane_en[g]),
            .wdata_in (wr_data[g*8 +: 8]),
            .capture  (capture),
            .dq_in    (mem_dq_in[g*8 +: 8]),
            .lane_n   (mem_lane_n[g]),
            .dq_out   (mem_dq_out[g*8 +: 8]),
            .rdata    (rd_data[g*8 +: 8])
        );
    end

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr))
        else $error("address moved during access");

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($stable(mem_lane_n) && $stable(mem_dq_out) && $stable(mem_addr)))
        else $error("write operands changed at end of write");

    assert_lanes_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_lane_n))
        else $error("lane enables moved during access");

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    // Cycle counts worked out from the timing limits at a 10 ns clock
    localparam int RD_N = 6;   // ceil(55/10)
    localparam int WP_N = 5;   // ceil(max(45,45,25,55-10)/10)
    localparam int TA_N = 2;   // ceil(20/10)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  lane_en = '0;
    logic        ready;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'h0000;
    logic        mem_dq_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wr_data(wr_data), .lane_en(lane_en), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory device model ----------------
    bit [15:0] dev_mem [int];
    bit        p_cs_n = 1'b1, p_we_n = 1'b1;
    int        rd_run = 0;

    function automatic bit [15:0] dev_get(input int a);
        return dev_mem.exists(a) ? dev_mem[a] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        bit [15:0] w;
        if (!p_cs_n && !p_we_n && (mem_we_n || mem_cs_n)) begin
            chk(mem_dq_oe === 1'b1, "R5 drive held at end of write", 32'(mem_dq_oe), 32'd1);
            w = dev_get(int'(mem_addr));
            for (int i = 0; i < 2; i++)
                if (!mem_lane_n[i]) w[i*8 +: 8] = mem_dq_out[i*8 +: 8];
            dev_mem[int'(mem_addr)] = w;
        end
        p_cs_n = mem_cs_n;
        p_we_n = mem_we_n;
        if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_run++;
        else rd_run = 0;
        w = dev_get(int'(mem_addr));
        for (int i = 0; i < 2; i++)
            mem_dq_in[i*8 +: 8] = (rd_run >= RD_N && !mem_lane_n[i]) ? w[i*8 +: 8] : 8'hA5;
    end

    // ---------------- reference model ----------------
    typedef struct {
        bit        cs_n, we_n, oe_n, drv;
        bit [1:0]  lane_n;
        bit [17:0] a;
        bit [15:0] d;
        bit        fin_rd;
        bit [15:0] rexp;
        int        kind; // 2 read, 4 strobe, 5 hold, 6 turn
    } exp_t;

    exp_t      q[$];
    bit [15:0] shadow [int];
    bit        m_last_rd = 0;
    bit        exp_rv = 0;
    bit [15:0] exp_rd = 0;

    function automatic bit [15:0] sh_get(input int a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        bit   was_ready;
        exp_t e;
        if (!rst_n) begin
            q.delete();
            m_last_rd = 0;
            exp_rv = 0;
        end else begin
            was_ready = (q.size() == 0);
            exp_rv = 0;
            if (!was_ready) begin
                e = q.pop_front();
                if (e.fin_rd) begin
                    exp_rv = 1;
                    exp_rd = e.rexp;
                end
            end
            if (was_ready && req) begin
                e = '{cs_n:1, we_n:1, oe_n:1, drv:0, lane_n:~lane_en, a:addr,
                      d:wr_data, fin_rd:0, rexp:0, kind:0};
                if (wr) begin
                    bit [15:0] w;
                    if (m_last_rd) begin
                        e.kind = 6;
                        for (int i = 0; i < TA_N; i++) q.push_back(e);
                    end
                    e.cs_n = 0; e.we_n = 0; e.drv = 1; e.kind = 4;
                    for (int i = 0; i < WP_N; i++) q.push_back(e);
                    e.cs_n = 1; e.we_n = 1; e.kind = 5;
                    q.push_back(e);
                    w = sh_get(int'(addr));
                    for (int i = 0; i < 2; i++)
                        if (lane_en[i]) w[i*8 +: 8] = wr_data[i*8 +: 8];
                    shadow[int'(addr)] = w;
                    m_last_rd = 0;
                end else begin
                    bit [15:0] r;
                    r = sh_get(int'(addr));
                    for (int i = 0; i < 2; i++)
                        if (!lane_en[i]) r[i*8 +: 8] = 8'h00;
                    e.cs_n = 0; e.oe_n = 0; e.kind = 2;
                    for (int i = 0; i < RD_N; i++) begin
                        e.fin_rd = (i == RD_N - 1);
                        e.rexp = r;
                        q.push_back(e);
                    end
                    m_last_rd = 1;
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(mem_dq_oe && !mem_oe_n), "R10 contention", {mem_dq_oe, mem_oe_n}, 32'b01);
            chk(rd_valid === exp_rv, "R3 rd_valid", 32'(rd_valid), 32'(exp_rv));
            if (exp_rv)
                chk(rd_data === exp_rd, "R3/R8 rd_data", 32'(rd_data), 32'(exp_rd));
            if (q.size() == 0) begin
                chk({ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} === 5'b11110,
                    "R7 idle strobes/ready", {ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'b11110);
            end else begin
                exp_t e;
                string tg;
                e = q[0];
                tg = (e.kind == 2) ? "R2 read strobes" : (e.kind == 4) ? "R4 write strobes" :
                     (e.kind == 5) ? "R5 hold cycle" : "R6 turnaround";
                chk({ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} === {1'b0, e.cs_n, e.we_n, e.oe_n, e.drv},
                    tg, {ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, {1'b0, e.cs_n, e.we_n, e.oe_n, e.drv});
                if (e.kind != 6) begin
                    chk(mem_addr === e.a, "R9 address", 32'(mem_addr), 32'(e.a));
                    chk(mem_lane_n === e.lane_n, "R2 lane enables", 32'(mem_lane_n), 32'(e.lane_n));
                end
                if (e.drv)
                    chk(mem_dq_out === e.d, "R4 write data", 32'(mem_dq_out), 32'(e.d));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic op(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] le);
        req = 1'b1; wr = w; addr = a; wr_data = d; lane_en = le;
        do @(negedge clk); while (!ready);
        @(posedge clk);
        #1;
        req = 1'b0; wr = 1'b0; wr_data = 16'hxxxx; lane_en = 2'bxx; addr = 18'hxxxxx;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, rd_valid} === 8'b11111100,
            "R1 reset state", {ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, rd_valid}, 32'hFC);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk({ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe} === 7'b1111110,
            "R1 after reset", {ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe}, 32'h7E);
        @(posedge clk); #1;

        op(1, 18'h00010, 16'h1234, 2'b11);   // R4 word write, request held off (R7)
        op(0, 18'h00010, 16'h0000, 2'b11);   // R2 read back
        op(1, 18'h00010, 16'hABCD, 2'b11);   // R6 write right after read
        op(0, 18'h00010, 16'h0000, 2'b11);
        idle(3);
        op(1, 18'h3FFFF, 16'h7781, 2'b01);   // R8 lower lane only
        op(1, 18'h3FFFF, 16'h9900, 2'b10);   // R8 upper lane only
        op(0, 18'h3FFFF, 16'h0000, 2'b11);   // expect 9981
        op(1, 18'h3FFFF, 16'hFFFF, 2'b00);   // R8 no lanes, R6 turn
        op(0, 18'h3FFFF, 16'h0000, 2'b11);   // still 9981
        op(0, 18'h3FFFF, 16'h0000, 2'b01);   // R3 upper lane reads zero
        op(0, 18'h3FFFF, 16'h0000, 2'b10);   // R3 lower lane reads zero
        op(0, 18'h3FFFF, 16'h0000, 2'b00);   // R3 nothing enabled
        idle(5);
        op(1, 18'h00000, 16'h5A5A, 2'b11);   // R6 turn even after idle gap
        op(1, 18'h00001, 16'hC3C3, 2'b11);   // write after write, no turn
        op(0, 18'h00000, 16'h0000, 2'b11);
        op(0, 18'h00001, 16'h0000, 2'b11);
        op(0, 18'h00010, 16'h0000, 2'b10);
        idle(12);
        finish_run();
    end

endmodule